// File: doc/BRIEF.md
# Readout Block Word Formatter

This block turns the readout of one digitizer module into a stream of tagged 32-bit words. Events are grouped into blocks. The first event of a block opens the block with a header word. Every event contributes an event header, a timestamp split into 24-bit slices, and the payload words that an upstream channel stage hands over. Once the configured number of events is in, a trailer word closes the block. The trailer carries the module's slot and the total number of words in the block, with the header and the trailer themselves counted.

Each event is offered on a valid/ready request that carries its trigger timestamp. The request is consumed once the last timestamp word has left. The payload follows as a valid/ready stream whose last word is flagged. The output is a valid/ready word stream meant to feed a FIFO. A word that starts a record has bit 31 set and a type code in bits 30:27. The codes are: 0 block header, 1 block trailer, 2 event header, 3 timestamp, 4 raw window data (the last one is produced upstream).

Top module: `evb_formatter`

## Requirements
- R1: The first event of a block is preceded by a block header word. Its layout is: bit 31 = 1, bits 30:27 = 0, bits 26:22 = slot_id, bits 21:18 = 0, bits 17:10 = events per block, bits 9:0 = block number.
- R2: Each event starts with an event header word. Its layout is: bit 31 = 1, bits 30:27 = 2, bits 26:0 = event number. The first event after reset is number 1, and the number rises by one for each event.
- R3: The event header is followed by the timestamp. The first word holds bit 31 = 1, bits 30:27 = 3, bits 26:24 = 0 and timestamp bits 23:0. The second word holds bits 31:24 = 0 and timestamp bits 47:24.
- R4: Payload words appear on out_data unchanged and in order, right after the timestamp words. pay_ready is high only while out_ready is high.
- R5: After the configured number of events, a trailer word is emitted. Its layout is: bit 31 = 1, bits 30:27 = 1, bits 26:22 = slot_id, bits 21:0 = the word count of the block. The count runs from the block header through the trailer, both included.
- R6: The first block after reset is number 0. The number rises by one, modulo 1024, after each trailer.
- R7: blk_level is sampled when a block opens. A value of 0 acts as 1. A change to blk_level in the middle of a block has no effect on that block's header or length.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R9: During reset, out_valid, ev_ready and pay_ready are low.
- R10: ev_ready is high only in the cycle in which the last timestamp word of that event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_id | input | 5 | Module slot number placed in headers and trailers |
| blk_level | input | LVL_W | Events per block (0 treated as 1) |
| ev_valid | input | 1 | Event request pending |
| ev_ready | output | 1 | Event request consumed |
| ev_time | input | TS_W | Trigger timestamp of the pending event |
| pay_valid | input | 1 | Payload word offered |
| pay_ready | output | 1 | Payload word taken |
| pay_data | input | 32 | Payload word |
| pay_last | input | 1 | Marks the final payload word of the event |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Output word |

## Verification
The formatter is driven with block levels 1, 3, 0 and 2. Payload lengths vary from event to event, so trailer counts that come only from a constant per-event size would be exposed. One phase stalls the output with an irregular out_ready pattern, which separates correct hold behaviour from words that are lost or repeated. One phase changes blk_level in the middle of a block, to show whether the level is latched when the block opens. A run of more than 1024 single-event blocks wraps the block number. Every output word is compared with a stream that the bench builds arithmetically from the requirements.

// File: rtl/evb_pkg.sv
package evb_pkg;
   // record type codes in bits 30:27 of a record-opening word
   typedef enum logic [3:0] {
      TAG_BHDR = 4'd0,
      TAG_BTRL = 4'd1,
      TAG_EHDR = 4'd2,
      TAG_TIME = 4'd3,
      TAG_WRAW = 4'd4
   } tag_e;

   typedef enum logic [2:0] {
      ST_WAIT,
      ST_BHDR,
      ST_EHDR,
      ST_TIME,
      ST_PAY,
      ST_TRL
   } st_e;

   localparam int WORD_W    = 32;
   localparam int SLOT_W    = 5;
   localparam int PIECE_W   = 24;
   localparam int NEVT_MAXW = 8;
   localparam int BNUM_MAXW = 10;
   localparam int ENUM_MAXW = 27;
   localparam int WCNT_MAXW = 22;
endpackage

// File: rtl/evb_ctrl.sv
module evb_ctrl
   import evb_pkg::*;
#(
   parameter int LVL_W  = 8,
   parameter int BLKN_W = 10,
   parameter int EVN_W  = 27,
   parameter int WC_W   = 22,
   parameter int NPIECE = 2,
   localparam int PC_W  = (NPIECE > 1) ? $clog2(NPIECE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  blk_level,
   input  logic              ev_valid,
   output logic              ev_ready,
   input  logic              pay_valid,
   input  logic              pay_last,
   output logic              pay_ready,
   input  logic              out_ready,
   output logic              out_valid,
   output st_e               st,
   output logic [PC_W-1:0]   piece,
   output logic [LVL_W-1:0]  lvl_q,
   output logic [BLKN_W-1:0] blk_num,
   output logic [EVN_W-1:0]  ev_num,
   output logic [WC_W-1:0]   wcnt
);
   localparam int LW1 = LVL_W + 1;
   localparam logic [PC_W-1:0] LAST_PIECE = PC_W'(NPIECE - 1);

   logic [LVL_W-1:0] evcnt;
   logic             fire;
   logic             blk_full;

   always_comb begin
      unique case (st)
         ST_WAIT: out_valid = 1'b0;
         ST_PAY:  out_valid = pay_valid;
         default: out_valid = 1'b1;
      endcase
   end

   assign fire      = out_valid & out_ready;
   assign pay_ready = (st == ST_PAY) & out_ready;
   assign ev_ready  = (st == ST_TIME) & (piece == LAST_PIECE) & out_ready;
   assign blk_full  = (LW1'(evcnt) + LW1'(1)) == LW1'(lvl_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_WAIT;
         piece   <= '0;
         lvl_q   <= LVL_W'(1);
         evcnt   <= '0;
         blk_num <= '0;
         ev_num  <= EVN_W'(1);
         wcnt    <= '0;
      end else begin
         if (fire) wcnt <= (st == ST_TRL) ? '0 : wcnt + WC_W'(1);
         unique case (st)
            ST_WAIT: if (ev_valid) begin
               if (evcnt == '0) begin
                  lvl_q <= (blk_level == '0) ? LVL_W'(1) : blk_level;
                  st    <= ST_BHDR;
               end else begin
                  st <= ST_EHDR;
               end
            end
            ST_BHDR: if (fire) st <= ST_EHDR;
            ST_EHDR: if (fire) begin
               st    <= ST_TIME;
               piece <= '0;
            end
            ST_TIME: if (fire) begin
               if (piece == LAST_PIECE) begin
                  st     <= ST_PAY;
                  ev_num <= ev_num + EVN_W'(1);
               end else begin
                  piece <= piece + PC_W'(1);
               end
            end
            ST_PAY: if (fire && pay_last) begin
               evcnt <= evcnt + LVL_W'(1);
               st    <= blk_full ? ST_TRL : ST_WAIT;
            end
            ST_TRL: if (fire) begin
               blk_num <= blk_num + BLKN_W'(1);
               evcnt   <= '0;
               st      <= ST_WAIT;
            end
            default: st <= ST_WAIT;
         endcase
      end
   end
endmodule

// File: rtl/evb_pack.sv
module evb_pack
   import evb_pkg::*;
#(
   parameter int TS_W   = 48,
   parameter int LVL_W  = 8,
   parameter int BLKN_W = 10,
   parameter int EVN_W  = 27,
   parameter int WC_W   = 22,
   localparam int NPIECE = TS_W / PIECE_W,
   localparam int PC_W   = (NPIECE > 1) ? $clog2(NPIECE) : 1
) (
   input  st_e               st,
   input  logic [PC_W-1:0]   piece,
   input  logic [SLOT_W-1:0] slot_id,
   input  logic [LVL_W-1:0]  lvl_q,
   input  logic [BLKN_W-1:0] blk_num,
   input  logic [EVN_W-1:0]  ev_num,
   input  logic [WC_W-1:0]   wcnt,
   input  logic [TS_W-1:0]   ev_time,
   input  logic [WORD_W-1:0] pay_data,
   output logic [WORD_W-1:0] word
);
   logic [PIECE_W-1:0] slices [NPIECE];

   for (genvar g = 0; g < NPIECE; g++) begin : g_slice
      assign slices[g] = ev_time[g*PIECE_W +: PIECE_W];
   end

   always_comb begin
      word = '0;
      unique case (st)
         ST_BHDR: begin
            word[31]           = 1'b1;
            word[30:27]        = TAG_BHDR;
            word[26:22]        = slot_id;
            word[10 +: LVL_W]  = lvl_q;
            word[0 +: BLKN_W]  = blk_num;
         end
         ST_EHDR: begin
            word[31]           = 1'b1;
            word[30:27]        = TAG_EHDR;
            word[0 +: EVN_W]   = ev_num;
         end
         ST_TIME: begin
            word[PIECE_W-1:0]  = slices[piece];
            if (piece == '0) begin
               word[31]        = 1'b1;
               word[30:27]     = TAG_TIME;
            end
         end
         ST_PAY:  word = pay_data;
         ST_TRL: begin
            word[31]           = 1'b1;
            word[30:27]        = TAG_BTRL;
            word[26:22]        = slot_id;
            word[0 +: WC_W]    = wcnt + WC_W'(1);
         end
         default: word = '0;
      endcase
   end
endmodule

// File: rtl/evb_formatter.sv
module evb_formatter
   import evb_pkg::*;
#(
   parameter int TS_W   = 48,
   parameter int LVL_W  = 8,
   parameter int BLKN_W = 10,
   parameter int EVN_W  = 27,
   parameter int WC_W   = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        slot_id,
   input  logic [LVL_W-1:0]  blk_level,
   input  logic              ev_valid,
   output logic              ev_ready,
   input  logic [TS_W-1:0]   ev_time,
   input  logic              pay_valid,
   output logic              pay_ready,
   input  logic [31:0]       pay_data,
   input  logic              pay_last,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [31:0]       out_data
);
   localparam int NPIECE = TS_W / PIECE_W;
   localparam int PC_W   = (NPIECE > 1) ? $clog2(NPIECE) : 1;

   if (TS_W % PIECE_W != 0 || TS_W < PIECE_W) begin : g_bad_ts
      $error("TS_W must be a nonzero multiple of the slice width");
   end
   if (LVL_W > NEVT_MAXW || LVL_W < 1) begin : g_bad_lvl
      $error("LVL_W does not fit its header field");
   end
   if (BLKN_W > BNUM_MAXW || EVN_W > ENUM_MAXW || WC_W > WCNT_MAXW) begin : g_bad_fld
      $error("counter width exceeds its word field");
   end

   st_e               st;
   logic [PC_W-1:0]   piece;
   logic [LVL_W-1:0]  lvl_q;
   logic [BLKN_W-1:0] blk_num;
   logic [EVN_W-1:0]  ev_num;
   logic [WC_W-1:0]   wcnt;

   evb_ctrl #(
      .LVL_W(LVL_W), .BLKN_W(BLKN_W), .EVN_W(EVN_W), .WC_W(WC_W), .NPIECE(NPIECE)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .blk_level(blk_level),
      .ev_valid(ev_valid), .ev_ready(ev_ready),
      .pay_valid(pay_valid), .pay_last(pay_last), .pay_ready(pay_ready),
      .out_ready(out_ready), .out_valid(out_valid),
      .st(st), .piece(piece), .lvl_q(lvl_q), .blk_num(blk_num),
      .ev_num(ev_num), .wcnt(wcnt)
   );

   evb_pack #(
      .TS_W(TS_W), .LVL_W(LVL_W), .BLKN_W(BLKN_W), .EVN_W(EVN_W), .WC_W(WC_W)
   ) u_pack (
      .st(st), .piece(piece), .slot_id(slot_id), .lvl_q(lvl_q),
      .blk_num(blk_num), .ev_num(ev_num), .wcnt(wcnt),
      .ev_time(ev_time), .pay_data(pay_data), .word(out_data)
   );
endmodule

// File: rtl/evb_checker.sv
module evb_checker (
   input logic        clk,
   input logic        rst_n,
   input logic [4:0]  slot_id,
   input logic        ev_valid,
   input logic        ev_ready,
   input logic        pay_valid,
   input logic        pay_ready,
   input logic [31:0] pay_data,
   input logic        out_valid,
   input logic        out_ready,
   input logic [31:0] out_data
);
   logic        fire, is_hdr, is_trl;
   logic [21:0] blk_words;
   logic [9:0]  last_bnum;
   logic        seen_hdr;

   assign fire   = out_valid & out_ready;
   assign is_hdr = out_data[31] & (out_data[30:27] == 4'd0);
   assign is_trl = out_data[31] & (out_data[30:27] == 4'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_words <= '0;
         last_bnum <= '0;
         seen_hdr  <= 1'b0;
      end else if (fire) begin
         blk_words <= is_trl ? '0 : blk_words + 22'd1;
         if (is_hdr) begin
            last_bnum <= out_data[9:0];
            seen_hdr  <= 1'b1;
         end
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r9: assert (!out_valid && !ev_ready && !pay_ready)
            else $error("R9 handshake active during reset");
      end
   end

   p_hdr_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fire && is_hdr |-> out_data[26:22] == slot_id);

   p_pay_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pay_ready |-> out_ready);

   p_pay_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pay_valid && pay_ready |-> out_valid && out_data == pay_data);

   p_trl_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fire && is_trl |-> out_data[21:0] == blk_words + 22'd1);

   p_bnum_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fire && is_hdr && seen_hdr |-> out_data[9:0] == last_bnum + 10'd1);

   p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   p_ev_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ready |-> ev_valid && fire && !out_data[31]);
endmodule

bind evb_formatter evb_checker u_chk (
   .clk(clk), .rst_n(rst_n), .slot_id(slot_id),
   .ev_valid(ev_valid), .ev_ready(ev_ready),
   .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/evb_formatter_test.sv
module evb_formatter_test;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_LIMIT = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  slot_id = 5'd19;
   logic [7:0]  blk_level = 8'd1;
   logic        ev_valid = 1'b0;
   logic        ev_ready;
   logic [47:0] ev_time = '0;
   logic        pay_valid = 1'b0;
   logic        pay_ready;
   logic [31:0] pay_data = '0;
   logic        pay_last = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_data;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit stall_en = 1'b0;

   logic [31:0] exp_q[$];
   int          req_q[$];
   logic [31:0] got_q[$];

   // bench reference model state
   int m_evcnt = 0;
   int m_lvl = 1;
   int m_blk = 0;
   int m_evn = 1;
   int m_wc = 0;

   bit          prev_stall = 1'b0;
   logic [31:0] prev_data = '0;

   evb_formatter uut (
      .clk(clk), .rst_n(rst_n), .slot_id(slot_id), .blk_level(blk_level),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_time(ev_time),
      .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
      .pay_last(pay_last), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == WDOG_LIMIT) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG_LIMIT);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
      #1 out_ready = !(stall_en && ((cyc % 3 == 1) || (cyc % 7 == 0)));
   end

   // monitor and protocol checks, sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall)
            check(out_valid && out_data == prev_data, "R8", out_data, prev_data);
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
         if (pay_ready) check(out_ready, "R4", 32'(out_ready), 32'd1);
         if (ev_ready)
            check(out_valid && out_ready && !out_data[31], "R10", out_data, 32'h0);
         if (out_valid && out_ready) got_q.push_back(out_data);
      end
   end

   function automatic void push(logic [31:0] w, int r);
      exp_q.push_back(w);
      req_q.push_back(r);
      m_wc++;
   endfunction

   task automatic send_event(int k, int npay);
      logic [47:0] t;
      t = {24'hA00000 + 24'(k), 24'h000100 + 24'(k * 5)};
      if (m_evcnt == 0) begin
         m_lvl = (blk_level == 0) ? 1 : int'(blk_level);
         m_wc  = 0;
         push({1'b1, 4'd0, slot_id, 4'd0, 8'(m_lvl), 10'(m_blk)}, 1);
      end
      push({1'b1, 4'd2, 27'(m_evn)}, 2);
      push({1'b1, 4'd3, 3'd0, t[23:0]}, 3);
      push({8'd0, t[47:24]}, 3);
      for (int i = 0; i < npay; i++)
         push((i == 0) ? {1'b1, 4'd4, 27'(k)} : {1'b0, 7'(i), 24'(k * 16 + i)}, 4);
      m_evn++;
      m_evcnt++;
      if (m_evcnt == m_lvl) begin
         push({1'b1, 4'd1, slot_id, 22'(m_wc + 1)}, 5);
         m_evcnt = 0;
         m_blk   = (m_blk + 1) % 1024;
      end
      ev_valid = 1'b1;
      ev_time  = t;
      do @(negedge clk); while (!ev_ready);
      @(posedge clk);
      #1 ev_valid = 1'b0;
      for (int i = 0; i < npay; i++) begin
         pay_valid = 1'b1;
         pay_data  = (i == 0) ? {1'b1, 4'd4, 27'(k)} : {1'b0, 7'(i), 24'(k * 16 + i)};
         pay_last  = (i == npay - 1);
         do @(negedge clk); while (!pay_ready);
         @(posedge clk);
         #1;
      end
      pay_valid = 1'b0;
      pay_last  = 1'b0;
   endtask

   task automatic drain();
      string tag;
      while (got_q.size() < exp_q.size()) @(posedge clk);
      repeat (4) @(posedge clk);
      #1;
      check(got_q.size() == exp_q.size(), "R5", 32'(got_q.size()), 32'(exp_q.size()));
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
         // 1:R1 header, 2:R2 event header, 3:R3 time, 4:R4 payload, 5:R5/R6 trailer
         case (req_q[i])
            1: tag = "R1/R6/R7";
            2: tag = "R2";
            3: tag = "R3";
            4: tag = "R4";
            default: tag = "R5";
         endcase
         check(got_q[i] == exp_q[i], tag, got_q[i], exp_q[i]);
      end
      exp_q.delete();
      req_q.delete();
      got_q.delete();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R9: quiet while held in reset
      check(!out_valid && !ev_ready && !pay_ready, "R9",
            {29'd0, out_valid, ev_ready, pay_ready}, 32'd0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // level 1, varied payload lengths
      blk_level = 8'd1;
      for (int k = 0; k < 4; k++) send_event(k, k + 1);
      drain();

      // level 3 with output stalls
      stall_en  = 1'b1;
      blk_level = 8'd3;
      for (int k = 10; k < 16; k++) send_event(k, (k % 4) + 1);
      drain();

      // level 0 acts as 1
      blk_level = 8'd0;
      for (int k = 20; k < 22; k++) send_event(k, 2);
      drain();

      // R7: level change mid-block is ignored by the open block
      slot_id   = 5'd4;
      blk_level = 8'd2;
      send_event(30, 3);
      blk_level = 8'd5;
      send_event(31, 1);
      for (int k = 32; k < 37; k++) send_event(k, 2);
      drain();
      stall_en = 1'b0;

      // R6: block number wraps at 1024
      blk_level = 8'd1;
      for (int k = 0; k < 1030; k++) begin
         send_event(100 + k, 1);
         if (k % 64 == 63) drain();
      end
      drain();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule